// File: doc/BRIEF.md
# Defect-Aware Segment Builder with Unit Exclusion

This block takes a per-cell defect map of a memory array and groups its cells into codeword segments. Cells are partitioned into equal units. A first pass counts the defects in every unit and marks the unit as excluded when its count is above a threshold. A second pass walks the units and gathers included units into segments. Each segment is sized to hold one user block plus the redundancy of the weakest code in a supplied table that still covers the defects inside the segment and a transient-fault margin.

Excluded units may sit inside a segment, so a segment is not contiguous. For every committed segment the block reports the first unit, the number of units spanned and the code index. It then streams a one-bit-per-unit inclusion mask over that span. A downstream configuration path consumes these records. Segments grow in whole units, so a segment always ends on a unit boundary.

Top module: `seg_builder`

## Requirements
- R1: A unit is included when its defect count is less than or equal to `thresh`. A threshold of 0 excludes any unit with a defect, and a threshold of `UNIT_LEN` or more keeps every unit.
- R2: Each attempt starts on an included unit with code index 0 and zero correction strength. It adds included units in ascending order until the included cells reach `BLK`.
- R3: A segment is committed when the defects of its included units plus `margin` do not exceed the strength of the selected code.
- R4: If more strength is needed and the table holds an adequate entry, the lowest index whose strength is at least the requirement is selected. The span then grows until the included cells reach `BLK` plus that entry's redundancy. Entry i sits at bits [i*STR_W +: STR_W] of `code_str` and [i*RED_W +: RED_W] of `code_red`, and the table is ordered by ascending strength.
- R5: If the requirement exceeds every strength in the table, the attempt is abandoned and a new one starts at the first included unit after the abandoned start.
- R6: After a commit, the next attempt starts at the first included unit after the segment's last unit.
- R7: A commit produces `seg_units` consecutive `bm_valid` cycles. Bit k of this stream is 1 when unit `seg_start`+k is included. `bm_last` marks bit `seg_units`-1. `seg_start`, `seg_units` and `seg_code` stay stable throughout the stream.
- R8: When the units run out before a segment can commit, the partial attempt is dropped, `done` pulses for one cycle and `busy` falls.
- R9: After `start` is accepted, the block consumes `NUNITS*UNIT_LEN` map bits, unit 0 first and in cell order. A map bit is consumed only in a cycle with `map_valid` high, and 1 means defective.
- R10: After reset `busy`, `done` and `bm_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; latches thresh, margin and table when idle |
| thresh | input | $clog2(UNIT_LEN+1) | Highest defect count of an included unit |
| margin | input | STR_W | Extra strength reserved for transient faults |
| code_str | input | NCODE*STR_W | Correction strength per code entry |
| code_red | input | NCODE*RED_W | Redundancy in cells per code entry |
| map_valid | input | 1 | Map bit present |
| map_bit | input | 1 | 1 = defective cell |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at end of run |
| seg_start | output | $clog2(NUNITS) | First unit of the segment |
| seg_units | output | $clog2(NUNITS+1) | Units spanned, included or not |
| seg_code | output | $clog2(NCODE) | Selected code index |
| bm_valid | output | 1 | Mask bit present |
| bm_bit | output | 1 | 1 = unit included |
| bm_last | output | 1 | Final mask bit of the segment |

## Verification
The bench targets a unit whose count equals the threshold, a unit with one defect under a zero threshold, and a threshold equal to the unit length. A design with an off-by-one comparison would shift the mask bits and the segment lengths. One case makes the requirement exceed the strongest entry. A design that failed to restart one unit later would report a segment starting at unit 0 or none at all. Further cases need a code upgrade, which shows whether the span is extended by the redundancy and whether the lowest adequate index is taken. Gapped map input and partial tails check that idle cycles are not counted as cells and that an unfinished tail produces no record.

// File: rtl/segb_pkg.sv
package segb_pkg;
  typedef enum logic [2:0] {
    W_IDLE, W_LOAD, W_SEEK, W_EXT_REQ, W_EXT_ACC, W_DECIDE, W_EMIT, W_END
  } walk_state_e;
endpackage

// File: rtl/segb_classifier.sv
module segb_classifier #(
  parameter int UNIT_LEN = 32,
  parameter int NUNITS   = 64,
  parameter int CW       = 6,
  parameter int UW       = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          map_valid,
  input  logic          map_bit,
  input  logic [CW-1:0] thresh,
  output logic          wr_en,
  output logic [UW-1:0] wr_addr,
  output logic [CW-1:0] wr_cnt,
  output logic          wr_ok,
  output logic          load_done
);
  localparam int PW = (UNIT_LEN > 1) ? $clog2(UNIT_LEN) : 1;

  logic          active;
  logic [PW-1:0] pos;
  logic [UW-1:0] unit;
  logic [CW-1:0] acc;
  logic [CW-1:0] acc_nx;

  assign acc_nx = acc + CW'(map_bit);

  always_ff @(posedge clk) begin
    wr_en     <= 1'b0;
    load_done <= 1'b0;
    if (rst) begin
      active  <= 1'b0;
      pos     <= '0;
      unit    <= '0;
      acc     <= '0;
      wr_addr <= '0;
      wr_cnt  <= '0;
      wr_ok   <= 1'b0;
    end else if (clear) begin
      active <= 1'b1;
      pos    <= '0;
      unit   <= '0;
      acc    <= '0;
    end else if (active && map_valid) begin
      if (pos == PW'(UNIT_LEN - 1)) begin
        wr_en   <= 1'b1;
        wr_addr <= unit;
        wr_cnt  <= acc_nx;
        wr_ok   <= (acc_nx <= thresh);
        pos     <= '0;
        acc     <= '0;
        unit    <= unit + UW'(1);
        if (unit == UW'(NUNITS - 1)) begin
          active    <= 1'b0;
          load_done <= 1'b1;
        end
      end else begin
        pos <= pos + PW'(1);
        acc <= acc_nx;
      end
    end
  end
endmodule

// File: rtl/segb_store.sv
module segb_store #(
  parameter int NUNITS = 64,
  parameter int CW     = 6,
  parameter int UW     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [UW-1:0]     wr_addr,
  input  logic [CW-1:0]     wr_cnt,
  input  logic              wr_ok,
  input  logic [UW-1:0]     rd_addr,
  output logic [CW-1:0]     rd_cnt,
  output logic [NUNITS-1:0] usable
);
  logic [CW-1:0] mem [NUNITS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_cnt;
    rd_cnt <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) usable <= '0;
    else if (wr_en) usable[wr_addr] <= wr_ok;
  end
endmodule

// File: rtl/segb_pick.sv
module segb_pick #(
  parameter int NCODE = 8,
  parameter int STR_W = 8,
  parameter int RED_W = 8,
  parameter int IW    = 3,
  parameter int RQW   = 13
) (
  input  logic [NCODE*STR_W-1:0] code_str,
  input  logic [NCODE*RED_W-1:0] code_red,
  input  logic [RQW-1:0]         req,
  output logic                   hit,
  output logic [IW-1:0]          idx,
  output logic [RQW-1:0]         sel_str,
  output logic [RED_W-1:0]       sel_red
);
  always_comb begin
    hit     = 1'b0;
    idx     = '0;
    sel_str = '0;
    sel_red = '0;
    for (int i = NCODE - 1; i >= 0; i--) begin
      if (RQW'(code_str[i*STR_W +: STR_W]) >= req) begin
        hit     = 1'b1;
        idx     = IW'(i);
        sel_str = RQW'(code_str[i*STR_W +: STR_W]);
        sel_red = code_red[i*RED_W +: RED_W];
      end
    end
  end
endmodule

// File: rtl/segb_walker.sv
module segb_walker import segb_pkg::*; #(
  parameter int UNIT_LEN = 32,
  parameter int NUNITS   = 64,
  parameter int BLK      = 512,
  parameter int RED_W    = 8,
  parameter int UW       = 6,
  parameter int NW       = 7,
  parameter int CW       = 6,
  parameter int DW       = 12,
  parameter int AW       = 14,
  parameter int RQW      = 13,
  parameter int IW       = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              load_done,
  input  logic [NUNITS-1:0] usable,
  input  logic [CW-1:0]     rd_cnt,
  input  logic              pick_hit,
  input  logic [IW-1:0]     pick_idx,
  input  logic [RQW-1:0]    pick_str,
  input  logic [RED_W-1:0]  pick_red,
  input  logic [RQW-1:0]    margin_ext,
  output logic [UW-1:0]     rd_addr,
  output logic [RQW-1:0]    req,
  output logic              busy,
  output logic              done,
  output logic              bm_valid,
  output logic              bm_bit,
  output logic              bm_last,
  output logic [UW-1:0]     seg_start,
  output logic [NW-1:0]     seg_units,
  output logic [IW-1:0]     seg_code
);
  walk_state_e    st;
  logic [NW-1:0]  cur, s, e, b;
  logic [AW-1:0]  cells, need;
  logic [DW-1:0]  defs;
  logic [RQW-1:0] tsel;
  logic [IW-1:0]  cidx;
  logic [AW-1:0]  cells_nx, need_pick;
  logic [DW-1:0]  defs_nx;
  logic           e_out, cur_out;

  assign cells_nx  = cells + AW'(UNIT_LEN);
  assign defs_nx   = defs + DW'(rd_cnt);
  assign need_pick = AW'(BLK) + AW'(pick_red);
  assign e_out     = (e >= NW'(NUNITS));
  assign cur_out   = (cur >= NW'(NUNITS));
  assign rd_addr   = e[UW-1:0];
  assign req       = RQW'(defs) + margin_ext;
  assign busy      = (st != W_IDLE);

  always_ff @(posedge clk) begin
    done     <= 1'b0;
    bm_valid <= 1'b0;
    bm_last  <= 1'b0;
    if (rst) begin
      st        <= W_IDLE;
      cur       <= '0;
      s         <= '0;
      e         <= '0;
      b         <= '0;
      cells     <= '0;
      need      <= '0;
      defs      <= '0;
      tsel      <= '0;
      cidx      <= '0;
      bm_bit    <= 1'b0;
      seg_start <= '0;
      seg_units <= '0;
      seg_code  <= '0;
    end else begin
      case (st)
        W_IDLE: if (go) st <= W_LOAD;
        W_LOAD: if (load_done) begin
          cur <= '0;
          st  <= W_SEEK;
        end
        W_SEEK: begin
          if (cur_out) st <= W_END;
          else if (usable[cur[UW-1:0]]) begin
            s     <= cur;
            e     <= cur;
            cells <= '0;
            defs  <= '0;
            tsel  <= '0;
            cidx  <= '0;
            need  <= AW'(BLK);
            st    <= W_EXT_REQ;
          end else cur <= cur + NW'(1);
        end
        W_EXT_REQ: begin
          if (e_out) st <= W_END;
          else if (usable[e[UW-1:0]]) st <= W_EXT_ACC;
          else e <= e + NW'(1);
        end
        W_EXT_ACC: begin
          cells <= cells_nx;
          defs  <= defs_nx;
          if (cells_nx >= need) st <= W_DECIDE;
          else begin
            e  <= e + NW'(1);
            st <= W_EXT_REQ;
          end
        end
        W_DECIDE: begin
          if (req <= tsel) begin
            seg_start <= s[UW-1:0];
            seg_units <= e - s + NW'(1);
            seg_code  <= cidx;
            b         <= s;
            st        <= W_EMIT;
          end else if (pick_hit) begin
            tsel <= pick_str;
            cidx <= pick_idx;
            need <= need_pick;
            if (cells < need_pick) begin
              e  <= e + NW'(1);
              st <= W_EXT_REQ;
            end
          end else begin
            cur <= s + NW'(1);
            st  <= W_SEEK;
          end
        end
        W_EMIT: begin
          bm_valid <= 1'b1;
          bm_bit   <= usable[b[UW-1:0]];
          bm_last  <= (b == e);
          if (b == e) begin
            cur <= e + NW'(1);
            st  <= W_SEEK;
          end else b <= b + NW'(1);
        end
        W_END: begin
          done <= 1'b1;
          st   <= W_IDLE;
        end
        default: st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_builder.sv
module seg_builder import segb_pkg::*; #(
  parameter int UNIT_LEN = 32,
  parameter int NUNITS   = 64,
  parameter int BLK      = 512,
  parameter int NCODE    = 8,
  parameter int STR_W    = 8,
  parameter int RED_W    = 8,
  localparam int UW  = $clog2(NUNITS),
  localparam int NW  = $clog2(NUNITS + 1),
  localparam int CW  = $clog2(UNIT_LEN + 1),
  localparam int IW  = $clog2(NCODE),
  localparam int DW  = $clog2(NUNITS * UNIT_LEN + 1),
  localparam int AW  = $clog2(NUNITS * UNIT_LEN + BLK + (1 << RED_W)) + 1,
  localparam int RQW = ((DW > STR_W) ? DW : STR_W) + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [CW-1:0]          thresh,
  input  logic [STR_W-1:0]       margin,
  input  logic [NCODE*STR_W-1:0] code_str,
  input  logic [NCODE*RED_W-1:0] code_red,
  input  logic                   map_valid,
  input  logic                   map_bit,
  output logic                   busy,
  output logic                   done,
  output logic [UW-1:0]          seg_start,
  output logic [NW-1:0]          seg_units,
  output logic [IW-1:0]          seg_code,
  output logic                   bm_valid,
  output logic                   bm_bit,
  output logic                   bm_last
);
  logic                   go;
  logic [CW-1:0]          thresh_q;
  logic [STR_W-1:0]       margin_q;
  logic [NCODE*STR_W-1:0] str_q;
  logic [NCODE*RED_W-1:0] red_q;

  logic              wr_en, wr_ok, load_done;
  logic [UW-1:0]     wr_addr, rd_addr;
  logic [CW-1:0]     wr_cnt, rd_cnt;
  logic [NUNITS-1:0] usable;
  logic [RQW-1:0]    req, pick_str;
  logic              pick_hit;
  logic [IW-1:0]     pick_idx;
  logic [RED_W-1:0]  pick_red;

  assign go = start & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      thresh_q <= '0;
      margin_q <= '0;
      str_q    <= '0;
      red_q    <= '0;
    end else if (go) begin
      thresh_q <= thresh;
      margin_q <= margin;
      str_q    <= code_str;
      red_q    <= code_red;
    end
  end

  segb_classifier #(.UNIT_LEN(UNIT_LEN), .NUNITS(NUNITS), .CW(CW), .UW(UW)) i_class (
    .clk(clk), .rst(rst), .clear(go), .map_valid(map_valid), .map_bit(map_bit),
    .thresh(thresh_q), .wr_en(wr_en), .wr_addr(wr_addr), .wr_cnt(wr_cnt),
    .wr_ok(wr_ok), .load_done(load_done)
  );

  segb_store #(.NUNITS(NUNITS), .CW(CW), .UW(UW)) i_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_cnt(wr_cnt),
    .wr_ok(wr_ok), .rd_addr(rd_addr), .rd_cnt(rd_cnt), .usable(usable)
  );

  segb_pick #(.NCODE(NCODE), .STR_W(STR_W), .RED_W(RED_W), .IW(IW), .RQW(RQW)) i_pick (
    .code_str(str_q), .code_red(red_q), .req(req), .hit(pick_hit),
    .idx(pick_idx), .sel_str(pick_str), .sel_red(pick_red)
  );

  segb_walker #(
    .UNIT_LEN(UNIT_LEN), .NUNITS(NUNITS), .BLK(BLK), .RED_W(RED_W), .UW(UW),
    .NW(NW), .CW(CW), .DW(DW), .AW(AW), .RQW(RQW), .IW(IW)
  ) i_walk (
    .clk(clk), .rst(rst), .go(go), .load_done(load_done), .usable(usable),
    .rd_cnt(rd_cnt), .pick_hit(pick_hit), .pick_idx(pick_idx),
    .pick_str(pick_str), .pick_red(pick_red), .margin_ext(RQW'(margin_q)),
    .rd_addr(rd_addr), .req(req), .busy(busy), .done(done),
    .bm_valid(bm_valid), .bm_bit(bm_bit), .bm_last(bm_last),
    .seg_start(seg_start), .seg_units(seg_units), .seg_code(seg_code)
  );
endmodule

// File: rtl/seg_builder_chk.sv
module seg_builder_chk #(
  parameter int UNIT_LEN = 32,
  parameter int NUNITS   = 64,
  parameter int BLK      = 512,
  parameter int UW       = 6,
  parameter int NW       = 7,
  parameter int IW       = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic [UW-1:0] seg_start,
  input logic [NW-1:0] seg_units,
  input logic [IW-1:0] seg_code,
  input logic          bm_valid,
  input logic          bm_bit,
  input logic          bm_last
);
  logic [NW-1:0] nb, no;

  always_ff @(posedge clk) begin
    if (rst) begin
      nb <= '0;
      no <= '0;
    end else if (bm_valid) begin
      if (bm_last) begin
        nb <= '0;
        no <= '0;
      end else begin
        nb <= nb + NW'(1);
        no <= no + NW'(bm_bit);
      end
    end
  end

  AST_HDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bm_valid && !bm_last) |=> (bm_valid && $stable(seg_start) && $stable(seg_units) && $stable(seg_code))); // R7
  AST_LEN_MATCH: assert property (@(posedge clk) disable iff (rst)
    (bm_valid && bm_last) |-> (int'(nb) + 1 == int'(seg_units))); // R7
  AST_FIRST_INCL: assert property (@(posedge clk) disable iff (rst)
    $rose(bm_valid) |-> bm_bit); // R2
  AST_LAST_INCL: assert property (@(posedge clk) disable iff (rst)
    (bm_valid && bm_last) |-> bm_bit); // R4
  AST_MIN_CELLS: assert property (@(posedge clk) disable iff (rst)
    (bm_valid && bm_last) |-> ((int'(no) + int'(bm_bit)) * UNIT_LEN >= BLK)); // R2
  AST_SPAN_FIT: assert property (@(posedge clk) disable iff (rst)
    bm_valid |-> (int'(seg_start) + int'(seg_units) <= NUNITS)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> (!bm_valid && $past(busy))); // R8
endmodule

bind seg_builder seg_builder_chk #(
  .UNIT_LEN(UNIT_LEN), .NUNITS(NUNITS), .BLK(BLK), .UW(UW), .NW(NW), .IW(IW)
) i_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .seg_start(seg_start),
  .seg_units(seg_units), .seg_code(seg_code), .bm_valid(bm_valid),
  .bm_bit(bm_bit), .bm_last(bm_last)
);

// File: tb/test_seg_builder.sv
module test_seg_builder;
  localparam int UL = 8, NU = 16, BK = 32, NC = 4, SW = 8, RW = 8;
  localparam int CW = $clog2(UL + 1), UW = $clog2(NU), NW = $clog2(NU + 1), IW = $clog2(NC);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, start, map_valid, map_bit;
  logic [CW-1:0] thresh;
  logic [SW-1:0] margin;
  logic [NC*SW-1:0] code_str;
  logic [NC*RW-1:0] code_red;
  logic busy, done, bm_valid, bm_bit, bm_last;
  logic [UW-1:0] seg_start;
  logic [NW-1:0] seg_units;
  logic [IW-1:0] seg_code;

  seg_builder #(.UNIT_LEN(UL), .NUNITS(NU), .BLK(BK), .NCODE(NC), .STR_W(SW), .RED_W(RW)) i_seg_builder (
    .clk(clk), .rst(rst), .start(start), .thresh(thresh), .margin(margin),
    .code_str(code_str), .code_red(code_red), .map_valid(map_valid), .map_bit(map_bit),
    .busy(busy), .done(done), .seg_start(seg_start), .seg_units(seg_units),
    .seg_code(seg_code), .bm_valid(bm_valid), .bm_bit(bm_bit), .bm_last(bm_last)
  );

  int checks = 0, failures = 0;
  int cnt [NU];
  int tstr [NC] = '{0, 2, 4, 8};
  int tred [NC] = '{0, 8, 16, 24};
  int e_n, g_n, cur_bm, cur_k;
  int e_s [NU], e_u [NU], e_c [NU], e_bm [NU];
  int g_s [NU], g_u [NU], g_c [NU], g_bm [NU];
  bit finished = 1'b0;

  always @(negedge clk) begin
    if (bm_valid) begin
      if (bm_bit) cur_bm = cur_bm | (1 << cur_k);
      cur_k++;
      if (bm_last) begin
        if (g_n < NU) begin
          g_s[g_n] = int'(seg_start);
          g_u[g_n] = int'(seg_units);
          g_c[g_n] = int'(seg_code);
          g_bm[g_n] = cur_bm;
        end
        g_n++;
        cur_bm = 0;
        cur_k = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, exp_v);
    end
  endtask

  task automatic clear_cnt();
    for (int u = 0; u < NU; u++) cnt[u] = 0;
  endtask

  task automatic model(input int th, input int mg);
    bit use_u [NU];
    int cur, s, nx, last, cells, def, t, idx, need, req, fin, stop;
    for (int u = 0; u < NU; u++) use_u[u] = (cnt[u] <= th);
    e_n = 0; cur = 0; fin = 0;
    while (!fin) begin
      s = cur;
      while (s < NU && !use_u[s]) s++;
      if (s >= NU) fin = 1;
      else begin
        t = 0; idx = 0; need = BK; cells = 0; def = 0; nx = s; last = s; stop = 0;
        while (!fin && !stop) begin
          while (!fin && cells < need) begin
            if (nx >= NU) fin = 1;
            else begin
              if (use_u[nx]) begin cells += UL; def += cnt[nx]; last = nx; end
              nx++;
            end
          end
          if (!fin) begin
            req = def + mg;
            if (req <= t) begin
              e_s[e_n] = s; e_u[e_n] = last - s + 1; e_c[e_n] = idx; e_bm[e_n] = 0;
              for (int k = s; k <= last; k++) if (use_u[k]) e_bm[e_n] |= (1 << (k - s));
              e_n++; cur = last + 1; stop = 1;
            end else if (req <= tstr[NC-1]) begin
              for (int i = NC - 1; i >= 0; i--) if (tstr[i] >= req) idx = i;
              t = tstr[idx]; need = BK + tred[idx];
            end else begin
              cur = s + 1; stop = 1;
            end
          end
        end
      end
    end
  endtask

  task automatic run_map(input int th, input int mg, input bit gap);
    int w;
    thresh = CW'(th); margin = SW'(mg);
    g_n = 0; cur_bm = 0; cur_k = 0;
    model(th, mg);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int u = 0; u < NU; u++) begin
      for (int j = 0; j < UL; j++) begin
        map_valid = 1'b1;
        map_bit = (((j * 5) % UL) < cnt[u]);
        @(negedge clk);
        if (gap) begin
          map_valid = 1'b0; map_bit = 1'b1;
          @(negedge clk);
        end
      end
    end
    map_valid = 1'b0; map_bit = 1'b0;
    w = 0;
    while (!done && w < 3000) begin @(negedge clk); w++; end
    chk(done === 1'b1, "R8 done pulse", int'(done), 1);
    @(negedge clk);
    chk(busy === 1'b0, "R8 busy low after run", int'(busy), 0);
  endtask

  task automatic compare();
    chk(g_n == e_n, "R8 segment count", g_n, e_n);
    for (int i = 0; i < e_n && i < g_n; i++) begin
      chk(g_s[i] == e_s[i], "R6 segment start", g_s[i], e_s[i]);
      chk(g_u[i] == e_u[i], "R4 units spanned", g_u[i], e_u[i]);
      chk(g_c[i] == e_c[i], "R3 code index", g_c[i], e_c[i]);
      chk(g_bm[i] == e_bm[i], "R7 inclusion mask", g_bm[i], e_bm[i]);
    end
  endtask

  task automatic t_reset();
    chk(busy === 1'b0, "R10 busy", int'(busy), 0);
    chk(done === 1'b0, "R10 done", int'(done), 0);
    chk(bm_valid === 1'b0, "R10 bm_valid", int'(bm_valid), 0);
  endtask

  task automatic t_clean();
    clear_cnt();
    run_map(1, 0, 1'b0);
    compare();
    chk(g_n == 4, "R2 four clean segments", g_n, 4);
    chk(g_u[0] == 4, "R2 span of BLK cells", g_u[0], 4);
  endtask

  task automatic t_margin();
    clear_cnt();
    run_map(1, 1, 1'b0);
    compare();
    chk(g_c[0] == 1, "R4 lowest adequate code", g_c[0], 1);
    chk(g_u[0] == 5, "R4 span grows by redundancy", g_u[0], 5);
  endtask

  task automatic t_thresh_zero();
    clear_cnt(); cnt[1] = 1;
    run_map(0, 0, 1'b0);
    compare();
    chk(g_bm[0] == 29, "R1 zero threshold excludes unit", g_bm[0], 29);
  endtask

  task automatic t_restart();
    clear_cnt(); cnt[0] = 8; cnt[1] = 2;
    run_map(8, 0, 1'b0);
    compare();
    chk(g_s[0] == 1, "R5 restart one unit later", g_s[0], 1);
    chk(g_c[0] == 1, "R5 code after restart", g_c[0], 1);
  endtask

  task automatic t_thresh_edge();
    clear_cnt(); cnt[3] = 2; cnt[6] = 3;
    run_map(2, 0, 1'b0);
    compare();
    chk(g_bm[0] == 31, "R1 count equal to threshold kept", g_bm[0], 31);
    chk(g_bm[1] == 29, "R1 count above threshold excluded", g_bm[1], 29);
  endtask

  task automatic t_full_keep();
    clear_cnt(); cnt[2] = 8;
    run_map(8, 0, 1'b0);
    compare();
    chk(g_c[0] == 3, "R1 full unit kept at threshold UNIT_LEN", g_c[0], 3);
  endtask

  task automatic t_gapped();
    for (int u = 0; u < NU; u++) cnt[u] = (u * 7) % 4;
    run_map(2, 1, 1'b1);
    compare();
    chk(g_n == e_n, "R9 idle map cycles ignored", g_n, e_n);
  endtask

  task automatic t_random();
    for (int r = 0; r < 3; r++) begin
      for (int u = 0; u < NU; u++) cnt[u] = $urandom_range(0, 3);
      run_map(2, r, 1'b0);
      compare();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start = 1'b0; map_valid = 1'b0; map_bit = 1'b0;
    thresh = '0; margin = '0;
    for (int i = 0; i < NC; i++) begin
      code_str[i*SW +: SW] = SW'(tstr[i]);
      code_red[i*RW +: RW] = RW'(tred[i]);
    end
    g_n = 0; cur_bm = 0; cur_k = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_clean();
    t_margin();
    t_thresh_zero();
    t_restart();
    t_thresh_edge();
    t_full_keep();
    t_gapped();
    t_random();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule